// File: doc/BRIEF.md
# Four-phase read responder with synchronized handshake

This block is the memory end of a read link whose requester runs on a clock of its own or on no clock. The requester controls a request line. A single acknowledge wire is driven by whichever party currently owns it. A 16-bit bus carries the address in one direction and the read word in the other. The responder samples both handshake lines into its local clock domain through two-flop synchronizers. It captures the address and acknowledges it. It then waits a programmable number of local cycles for its internal memory, presents the word and raises data-ready. It withdraws the word once the requester acknowledges it.

The exchange is made of two full four-phase handshakes in sequence: one moves the address, the other moves the data. No step depends on how fast the requester is. The access delay runs at the same time as the release of the address handshake. The bus and the acknowledge wire are each split into an input, an output value and a drive-enable, so the surrounding logic can build the shared wires.

Top module: `rd_resp_4ph`

## Requirements
- R1: While reset is active and right after it, ack_oe_o, ack_o, drdy_o and bus_oe_o are all low.
- R2: In idle, once the synchronized request is high, the block captures bus_i and drives the acknowledge wire high (ack_oe_o = ack_o = 1). ack_o rises on the third rising clock edge after req_i rises: two synchronizer stages, then the state register.
- R3: The block drives acknowledge only while it owns the address handshake. It keeps ack_o high for as long as the synchronized request stays high. It releases the wire (ack_oe_o = 0) only after it has seen request low.
- R4: The access delay LAT (default 6) starts on the edge where the address is captured. drdy_o cannot rise earlier than LAT+1 edges after ack_o rises.
- R5: drdy_o rises only after the block has released acknowledge and has seen, through its synchronizer, the acknowledge wire low. If the requester lowers req_i d cycles after it sees ack_o, drdy_o rises max(LAT+1, d+6) edges after ack_o rose.
- R6: While drdy_o is high, bus_oe_o is high and bus_o carries the memory word. The memory has DEPTH (default 16) entries. Entry i holds (16'hC000 + 37*i) mod 2^16. The entry is picked by the low log2(DEPTH) bits of the captured address.
- R7: When the synchronized acknowledge goes high, drdy_o and bus_oe_o fall together on the third edge after the acknowledge rose. The block then waits for acknowledge low before it returns to idle.
- R8: A request raised while data is being presented or withdrawn gets no acknowledge. It is taken up only once the block is back in idle, and the address on bus_i at that point is the one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request from the requester, asynchronous |
| ack_i | input | 1 | Level of the shared acknowledge wire, asynchronous |
| ack_o | output | 1 | Value the block drives onto the acknowledge wire |
| ack_oe_o | output | 1 | Drive-enable of the acknowledge wire |
| drdy_o | output | 1 | Data-ready to the requester |
| bus_i | input | 16 | Level of the shared address/data bus |
| bus_o | output | 16 | Read word driven onto the bus |
| bus_oe_o | output | 1 | Drive-enable of the bus |

## Verification
The two events that can land on the same edge are the end of the access-delay count and the synchronized sight of the released acknowledge wire. Both are conditions for raising data-ready. The bench varies how long the requester keeps request high after it sees acknowledge, from 0 to 8 cycles. With the default delay, a 1-cycle hold makes both conditions come true on the same edge. For each hold it counts the edges from ack_o to drdy_o and compares them with max(LAT+1, d+6). The scoreboard checks the word that is presented each time.

// File: rtl/rresp_pkg.sv
package rresp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_DONE = 3'd4
  } rr_state_e;
endpackage

// File: rtl/rr_sync2.sv
module rr_sync2 #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rr_lat_cnt.sv
module rr_lat_cnt #(
  parameter int unsigned LAT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LAT + 1);
  localparam logic [CW-1:0] LOAD = CW'(LAT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // a fresh count is never already finished
  assert_count_open_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/rr_word_rom.sv
module rr_word_rom #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned BASE  = 16'hC000,
  parameter int unsigned STEP  = 37
) (
  input  logic [$clog2(DEPTH)-1:0] idx_i,
  output logic [DW-1:0]            word_o
);
  logic [DW-1:0] words [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign words[i] = DW'(BASE + STEP * i);
  end

  assign word_o = words[idx_i];
endmodule

// File: rtl/rd_resp_4ph.sv
module rd_resp_4ph
  import rresp_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LAT   = 6,
  parameter int unsigned BASE  = 16'hC000,
  parameter int unsigned STEP  = 37
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_i,
  output logic          ack_o,
  output logic          ack_oe_o,
  output logic          drdy_o,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  rr_state_e     state_q, state_d;
  logic          req_s, ack_s;
  logic          latch, lat_done, load_data;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q, rom_word;

  rr_sync2 #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({req_i, ack_i}),
    .q_o   ({req_s, ack_s})
  );

  rr_lat_cnt #(.LAT(LAT)) u_lat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(latch),
    .done_o (lat_done)
  );

  rr_word_rom #(.DW(DW), .DEPTH(DEPTH), .BASE(BASE), .STEP(STEP)) u_rom (
    .idx_i (addr_q),
    .word_o(rom_word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_s)                state_d = ST_ADDR;
      ST_ADDR: if (!req_s)               state_d = ST_WAIT;
      ST_WAIT: if (lat_done && !ack_s)   state_d = ST_DATA; // own ack off and line seen low
      ST_DATA: if (ack_s)                state_d = ST_DONE;
      ST_DONE: if (!ack_s)               state_d = ST_IDLE;
      default:                           state_d = ST_IDLE;
    endcase
  end

  assign latch     = (state_q == ST_IDLE) && req_s;
  assign load_data = (state_q == ST_WAIT) && (state_d == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (latch)     addr_q <= bus_i[AW-1:0];
      if (load_data) data_q <= rom_word;
    end
  end

  assign ack_oe_o = (state_q == ST_ADDR);
  assign ack_o    = ack_oe_o;
  assign drdy_o   = (state_q == ST_DATA);
  assign bus_oe_o = (state_q == ST_DATA);
  assign bus_o    = bus_oe_o ? data_q : '0;

  assert_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_oe_o) |-> $past(req_s));
  assert_ack_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_oe_o && req_s) |=> ack_oe_o);
  assert_ack_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_oe_o) |-> !$past(req_s));
  assert_drdy_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drdy_o) |-> ($past(lat_done) && !$past(ack_s)));
  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_o |-> (!drdy_o && !bus_oe_o));
  assert_data_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_o && !ack_s) |=> drdy_o);
  assert_data_drop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drdy_o) |-> ($past(ack_s) && !bus_oe_o));
  assert_ignore_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drdy_o && req_s) |=> !ack_oe_o);
endmodule

// File: tb/sim_rd_resp_4ph.sv
module sim_rd_resp_4ph;
  localparam int LAT = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        ack_drv = 1'b0;
  logic [15:0] bus_drv = '0;
  logic        ack_o, ack_oe_o, drdy_o, bus_oe_o;
  logic [15:0] bus_o;
  logic        ack_line;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [15:0] exp_q[$];
  logic drdy_prev = 1'b0;

  always #4 clk = ~clk;

  assign ack_line = ack_drv | (ack_oe_o & ack_o);

  rd_resp_4ph #(.LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_i(ack_line),
    .ack_o(ack_o), .ack_oe_o(ack_oe_o), .drdy_o(drdy_o),
    .bus_i(bus_drv), .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  function automatic logic [15:0] word_of(input logic [15:0] a);
    return 16'(32'hC000 + 37 * int'(a[3:0]));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: compare each presented word against the queue
  always @(negedge clk) begin
    if (drdy_o && !drdy_prev) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected word", int'(bus_o), 0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(bus_oe_o && bus_o == e, "R6 read word", int'(bus_o), int'(e));
      end
    end
    drdy_prev = drdy_o;
  end

  task automatic data_close(input bit inject, input logic [15:0] a2);
    int k;
    if (inject) begin
      req = 1'b1;
      bus_drv = a2;
      exp_q.push_back(word_of(a2));
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        check(!ack_oe_o && drdy_o, "R8 no ack during data", int'(ack_oe_o), 0);
      end
    end
    ack_drv = 1'b1;
    k = 0;
    while (drdy_o) begin @(negedge clk); k++; end
    check(k == 3, "R7 drop delay", k, 3);
    check(!bus_oe_o, "R7 bus released", int'(bus_oe_o), 0);
    check(!ack_oe_o, "R8 no ack before idle", int'(ack_oe_o), 0);
    ack_drv = 1'b0;
  endtask

  task automatic txn(input logic [15:0] a, input int d, input bit inject, input logic [15:0] a2);
    int n, m, e;
    @(negedge clk);
    bus_drv = a;
    req = 1'b1;
    exp_q.push_back(word_of(a));
    n = 0;
    while (!ack_o) begin @(negedge clk); n++; end
    check(n == 3 && ack_oe_o, "R2 ack rise delay", n, 3);
    m = 0;
    for (int i = 0; i < d; i++) begin
      @(negedge clk); m++;
      check(ack_oe_o && ack_o, "R3 ack held while req high", int'(ack_o), 1);
    end
    req = 1'b0;
    bus_drv = 16'h0;
    while (!drdy_o) begin @(negedge clk); m++; end
    e = (LAT + 1 > d + 6) ? LAT + 1 : d + 6;
    check(m == e, "R4 R5 ack-to-drdy edges", m, e);
    data_close(inject, a2);
    if (inject) begin
      while (!ack_o) @(negedge clk);
      check(ack_oe_o, "R8 deferred request taken", int'(ack_oe_o), 1);
      @(negedge clk);
      req = 1'b0;
      bus_drv = 16'h0;
      while (!drdy_o) @(negedge clk);
      data_close(1'b0, 16'h0);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!ack_oe_o && !ack_o && !drdy_o && !bus_oe_o, "R1 in reset",
          int'({ack_oe_o, ack_o, drdy_o, bus_oe_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!ack_oe_o && !ack_o && !drdy_o && !bus_oe_o, "R1 after reset",
          int'({ack_oe_o, ack_o, drdy_o, bus_oe_o}), 0);
    txn(16'h0000, 0, 1'b0, 16'h0);
    txn(16'h0005, 1, 1'b0, 16'h0);  // delay end and ack sight on one edge
    txn(16'h000F, 2, 1'b0, 16'h0);
    txn(16'h0013, 3, 1'b0, 16'h0);  // only low index bits used
    txn(16'hFFFF, 8, 1'b0, 16'h0);
    txn(16'h0007, 1, 1'b1, 16'h00A9);
    txn(16'h000A, 0, 1'b0, 16'h0);
    check(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);
    finish_run();
  end
endmodule